// File: doc/BRIEF.md
# Reconfigurable Dual-Half Interval Timer

The block holds two counter/period pairs of equal width and arranges them, under a mode input, in one of three ways. They can form one counter of double width. They can form two unrelated timers, where the upper one is slowed by a small prescaler. They can also form a chain, where the upper pair divides the input ticks and clocks the lower pair. Every arrangement uses the same enable rules: hold, run to the period once, or run and wrap forever.

Each timer raises a one-clock event pulse when its count matches its period. The pulse serves as an interrupt request and as a DMA request. Counting is driven by an internal tick-enable or by an external pin, which is synchronised and edge-detected, with optional inversion. Counters are preset through load strobes. Register decoding and output waveform shaping are done outside the block.

Top module: `timer_core`

## Requirements
- R1: After reset both counts are 0 and both event outputs are low.
- R2: With mode=0 the two counts form one counter {countHi,countLo} with period {periodHi,periodLo}, driven by loEna. It counts input ticks, with carry from the low half into the high half. On the tick where it equals the period it pulses loEvent, and in loop mode it returns to 0, so one lap is period+1 ticks. hiEvent never pulses in modes 0 and 3.
- R3: With mode=1 the lower timer counts lower-source ticks against periodLo and pulses loEvent. The upper timer advances once every psPeriod+1 internal ticks through a 4-bit prescale count, is compared with periodHi, pulses hiEvent, and follows hiEna.
- R4: With mode=3 the upper count divides input ticks by periodHi+1 and clears on each match. Each such match advances the lower timer by one. Only loEna applies, and hiEna has no effect.
- R5: Enable code 1 (once) stops the count at the period after exactly one event. It stays stopped until the enable code is changed.
- R6: Enable code 0 (hold) and code 3 (reserved) keep the count unchanged while ticks arrive.
- R7: A count loaded above its period counts up to all-ones, wraps to 0, and carries on to the period match.
- R8: A timer whose period is 0 does not advance from a count of 0 and raises no event.
- R9: A low loRun freezes the lower count and suppresses its event, while the upper timer in mode 1 carries on. Modes 0 and 3 count only when loRun and hiRun are both high.
- R10: With suspend=1 and freeRun=1 counting is unaffected. With freeRun=0 and softStop=0 counting halts at once. With freeRun=0 and softStop=1 a timer counts up to its period and holds there without an event until suspend is released.
- R11: With clkSel=1 the lower source is the external pin, passed through two flops. Each rising edge of (extIn XOR extInvert) gives one tick. In mode 1 the upper timer keeps using tickInt.
- R12: Event outputs are single-cycle pulses.
- R13: loadLo or loadHi writes loadData into that count at the next clock edge, and takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 0 joined, 1 independent, 3 chained, 2 reserved (nothing counts) |
| loRun | input | 1 | Lower half out of soft reset |
| hiRun | input | 1 | Upper half out of soft reset |
| loEna | input | 2 | Lower enable: 0 hold, 1 once, 2 loop, 3 hold |
| hiEna | input | 2 | Upper enable, used in mode 1 only |
| psPeriod | input | PS_W | Upper prescale period in mode 1 |
| clkSel | input | 1 | 1 selects the external pin as the lower tick source |
| extIn | input | 1 | External count input, asynchronous |
| extInvert | input | 1 | Counts falling edges of extIn when 1 |
| tickInt | input | 1 | Internal count-enable tick |
| freeRun | input | 1 | Ignore suspend |
| softStop | input | 1 | On suspend, stop at the period instead of at once |
| suspend | input | 1 | Debug halt request |
| loadLo | input | 1 | Write loadData into the lower count |
| loadHi | input | 1 | Write loadData into the upper count |
| loadData | input | CNT_W | Preset value |
| periodLo | input | CNT_W | Lower period |
| periodHi | input | CNT_W | Upper period |
| countLo | output | CNT_W | Lower count |
| countHi | output | CNT_W | Upper count |
| loEvent | output | 1 | Lower match pulse (interrupt and DMA request) |
| hiEvent | output | 1 | Upper match pulse, mode 1 only |

## Verification
The properties assume that no load strobe lands on a cycle whose following count they inspect. The single-pulse property also assumes that a count is never loaded to its period on consecutive cycles. The stimulus changes the configuration only on falling clock edges, and it presets counts only while the affected timer is held, never in the middle of a checked window. Periods in the sweeps are at least 1 wherever back-to-back matches could otherwise occur. The polarity input is changed only while counting is off, because the polarity change itself can be seen as one extra edge.

// File: rtl/timer_pkg.sv
`timescale 1ns/1ps
package timer_pkg;
  typedef enum logic [1:0] {
    MODE_WIDE  = 2'd0,
    MODE_SPLIT = 2'd1,
    MODE_RSVD  = 2'd2,
    MODE_CHAIN = 2'd3
  } modeT;

  typedef enum logic [1:0] {
    ENA_HOLD = 2'd0,
    ENA_ONCE = 2'd1,
    ENA_LOOP = 2'd2,
    ENA_RSVD = 2'd3
  } enaT;

  // strobes from control to datapath for one clock edge
  typedef struct packed {
    logic stepLo;
    logic clrLo;
    logic stepHi;
    logic clrHi;
    logic stepWide;
    logic clrWide;
    logic evtLo;
    logic evtHi;
  } strobeT;
endpackage

// File: rtl/timer_ctrl.sv
`timescale 1ns/1ps
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int PS_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      mode,
  input  logic            loRun,
  input  logic            hiRun,
  input  logic [1:0]      loEna,
  input  logic [1:0]      hiEna,
  input  logic [PS_W-1:0] psPeriod,
  input  logic            clkSel,
  input  logic            extIn,
  input  logic            extInvert,
  input  logic            tickInt,
  input  logic            freeRun,
  input  logic            softStop,
  input  logic            suspend,
  input  logic            eqLo,
  input  logic            eqHi,
  input  logic            eqWide,
  input  logic            zeroLo,
  input  logic            zeroHi,
  input  logic            zeroWide,
  output strobeT          stb
);
  localparam int SYNC_N = 2;

  modeT modeV;
  enaT  loEnaV, hiEnaV;
  assign modeV  = modeT'(mode);
  assign loEnaV = enaT'(loEna);
  assign hiEnaV = enaT'(hiEna);

  // external input: synchroniser, polarity, rising-edge tick
  logic [SYNC_N-1:0] syncQ;
  logic              levelPrev, extTick, extLevel;
  assign extLevel = syncQ[SYNC_N-1] ^ extInvert;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ     <= '0;
      levelPrev <= 1'b0;
      extTick   <= 1'b0;
    end else begin
      syncQ     <= {syncQ[SYNC_N-2:0], extIn};
      levelPrev <= extLevel;
      extTick   <= extLevel & ~levelPrev;
    end
  end

  logic loTick, haltHard, softHold;
  assign loTick   = clkSel ? extTick : tickInt;
  assign haltHard = suspend & ~freeRun & ~softStop;
  assign softHold = suspend & ~freeRun & softStop;

  logic loGate, hiGate, loOn, hiOn, doneLo, doneHi;
  always_comb begin
    unique case (modeV)
      MODE_SPLIT:            loGate = loRun;
      MODE_WIDE, MODE_CHAIN: loGate = loRun & hiRun;
      default:               loGate = 1'b0;
    endcase
  end
  assign hiGate = (modeV == MODE_SPLIT) & hiRun;
  assign loOn = loGate & ((loEnaV == ENA_ONCE) | (loEnaV == ENA_LOOP)) & ~doneLo & ~haltHard;
  assign hiOn = hiGate & ((hiEnaV == ENA_ONCE) | (hiEnaV == ENA_LOOP)) & ~doneHi & ~haltHard;

  // chained: upper half divides ticks for the lower half
  logic chainTick, chainAdv, chainStep;
  assign chainTick = (modeV == MODE_CHAIN) & loOn & loTick;
  assign chainAdv  = chainTick & eqHi;
  assign chainStep = chainTick & ~eqHi;

  // lower timer role
  logic loAdv, loEq, loZero, loMatch, loStep, loWrap, isWide;
  assign isWide  = (modeV == MODE_WIDE);
  assign loAdv   = (modeV == MODE_CHAIN) ? chainAdv : (loOn & loTick);
  assign loEq    = isWide ? eqWide : eqLo;
  assign loZero  = isWide ? zeroWide : zeroLo;
  assign loMatch = loAdv & ~loZero & loEq & ~softHold;
  assign loStep  = loAdv & ~loZero & ~loEq;
  assign loWrap  = loMatch & (loEnaV == ENA_LOOP);

  // upper timer role in independent mode, behind the small prescaler
  logic [PS_W-1:0] psCnt;
  logic            psHit, hiAdv, hiMatch, hiStep, hiWrap;
  assign psHit   = (psCnt == psPeriod);
  assign hiAdv   = hiOn & tickInt & psHit;
  assign hiMatch = hiAdv & ~zeroHi & eqHi & ~softHold;
  assign hiStep  = hiAdv & ~zeroHi & ~eqHi;
  assign hiWrap  = hiMatch & (hiEnaV == ENA_LOOP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCnt  <= '0;
      doneLo <= 1'b0;
      doneHi <= 1'b0;
    end else begin
      if (!hiGate)                psCnt <= '0;
      else if (hiOn && tickInt)   psCnt <= psHit ? '0 : psCnt + 1'b1;

      if (!loGate || loEnaV != ENA_ONCE) doneLo <= 1'b0;
      else if (loMatch)                  doneLo <= 1'b1;

      if (!hiGate || hiEnaV != ENA_ONCE) doneHi <= 1'b0;
      else if (hiMatch)                  doneHi <= 1'b1;
    end
  end

  always_comb begin
    stb          = '0;
    stb.stepWide = isWide & loStep;
    stb.clrWide  = isWide & loWrap;
    stb.stepLo   = ~isWide & loStep;
    stb.clrLo    = ~isWide & loWrap;
    stb.stepHi   = chainStep | hiStep;
    stb.clrHi    = chainAdv | hiWrap;
    stb.evtLo    = loMatch;
    stb.evtHi    = hiMatch;
  end
endmodule

// File: rtl/timer_dp.sv
`timescale 1ns/1ps
module timer_dp
  import timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           stb,
  input  logic             loadLo,
  input  logic             loadHi,
  input  logic [CNT_W-1:0] loadData,
  input  logic [CNT_W-1:0] periodLo,
  input  logic [CNT_W-1:0] periodHi,
  output logic [CNT_W-1:0] countLo,
  output logic [CNT_W-1:0] countHi,
  output logic             loEvent,
  output logic             hiEvent,
  output logic             eqLo,
  output logic             eqHi,
  output logic             eqWide,
  output logic             zeroLo,
  output logic             zeroHi,
  output logic             zeroWide
);
  localparam int WIDE_W = 2 * CNT_W;

  logic [WIDE_W-1:0] wideSum;
  assign wideSum  = {countHi, countLo} + WIDE_W'(1);
  assign eqLo     = (countLo == periodLo);
  assign eqHi     = (countHi == periodHi);
  assign eqWide   = eqLo & eqHi;
  assign zeroLo   = (periodLo == '0);
  assign zeroHi   = (periodHi == '0);
  assign zeroWide = zeroLo & zeroHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countLo <= '0;
      countHi <= '0;
      loEvent <= 1'b0;
      hiEvent <= 1'b0;
    end else begin
      if (loadLo)                       countLo <= loadData;
      else if (stb.clrLo | stb.clrWide) countLo <= '0;
      else if (stb.stepLo)              countLo <= countLo + 1'b1;
      else if (stb.stepWide)            countLo <= wideSum[CNT_W-1:0];

      if (loadHi)                       countHi <= loadData;
      else if (stb.clrHi | stb.clrWide) countHi <= '0;
      else if (stb.stepHi)              countHi <= countHi + 1'b1;
      else if (stb.stepWide)            countHi <= wideSum[WIDE_W-1:CNT_W];

      loEvent <= stb.evtLo;
      hiEvent <= stb.evtHi;
    end
  end
endmodule

// File: rtl/timer_core.sv
`timescale 1ns/1ps
module timer_core
  import timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PS_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       mode,
  input  logic             loRun,
  input  logic             hiRun,
  input  logic [1:0]       loEna,
  input  logic [1:0]       hiEna,
  input  logic [PS_W-1:0]  psPeriod,
  input  logic             clkSel,
  input  logic             extIn,
  input  logic             extInvert,
  input  logic             tickInt,
  input  logic             freeRun,
  input  logic             softStop,
  input  logic             suspend,
  input  logic             loadLo,
  input  logic             loadHi,
  input  logic [CNT_W-1:0] loadData,
  input  logic [CNT_W-1:0] periodLo,
  input  logic [CNT_W-1:0] periodHi,
  output logic [CNT_W-1:0] countLo,
  output logic [CNT_W-1:0] countHi,
  output logic             loEvent,
  output logic             hiEvent
);
  strobeT stb;
  logic eqLo, eqHi, eqWide, zeroLo, zeroHi, zeroWide;

  timer_ctrl #(.PS_W(PS_W)) uCtrl (
    .clk(clk), .rstN(rstN), .mode(mode), .loRun(loRun), .hiRun(hiRun),
    .loEna(loEna), .hiEna(hiEna), .psPeriod(psPeriod), .clkSel(clkSel),
    .extIn(extIn), .extInvert(extInvert), .tickInt(tickInt),
    .freeRun(freeRun), .softStop(softStop), .suspend(suspend),
    .eqLo(eqLo), .eqHi(eqHi), .eqWide(eqWide),
    .zeroLo(zeroLo), .zeroHi(zeroHi), .zeroWide(zeroWide), .stb(stb)
  );

  timer_dp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .loadLo(loadLo), .loadHi(loadHi),
    .loadData(loadData), .periodLo(periodLo), .periodHi(periodHi),
    .countLo(countLo), .countHi(countHi), .loEvent(loEvent), .hiEvent(hiEvent),
    .eqLo(eqLo), .eqHi(eqHi), .eqWide(eqWide),
    .zeroLo(zeroLo), .zeroHi(zeroHi), .zeroWide(zeroWide)
  );
endmodule

// File: rtl/timer_core_chk.sv
`timescale 1ns/1ps
module timer_core_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       mode,
  input logic             loRun,
  input logic [1:0]       loEna,
  input logic             loadLo,
  input logic             freeRun,
  input logic             softStop,
  input logic             suspend,
  input logic [CNT_W-1:0] periodLo,
  input logic [CNT_W-1:0] countLo,
  input logic             loEvent,
  input logic             hiEvent
);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd1 && loRun && loEna == 2'd0 && !loadLo) |=> $stable(countLo));

  assert_freeze_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!loRun && !loadLo) |=> ($stable(countLo) && !loEvent));

  assert_hard_halt_R10: assert property (@(posedge clk) disable iff (!rstN)
    (suspend && !freeRun && !softStop && !loadLo) |=> $stable(countLo));

  assert_zero_period_R8: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd1 && countLo == '0 && periodLo == '0 && !loadLo) |=> (countLo == '0 && !loEvent));

  assert_hi_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 2'd1) |=> !hiEvent);

  assert_lo_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    loEvent |=> !loEvent);

  assert_hi_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    hiEvent |=> !hiEvent);
endmodule

bind timer_core timer_core_chk #(.CNT_W(CNT_W)) uChk (.*);

// File: tb/sim_timer_core.sv
`timescale 1ns/1ps
module sim_timer_core;
  localparam int W = 8;
  localparam int PW = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] mode = 2'd0, loEna = 2'd0, hiEna = 2'd0;
  logic loRun = 1'b0, hiRun = 1'b0, clkSel = 1'b0, extIn = 1'b0, extInvert = 1'b0;
  logic tickInt = 1'b1, freeRun = 1'b0, softStop = 1'b0, suspend = 1'b0;
  logic loadLo = 1'b0, loadHi = 1'b0;
  logic [PW-1:0] psPeriod = '0;
  logic [W-1:0] loadData = '0, periodLo = '0, periodHi = '0;
  logic [W-1:0] countLo, countHi;
  logic loEvent, hiEvent;

  int checks = 0, errors = 0, evLo = 0, evHi = 0, backToBack = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  timer_core #(.CNT_W(W), .PS_W(PW)) u0 (.*);

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runTicks(input int n);
    logic prevLo = 1'b0;
    evLo = 0; evHi = 0;
    repeat (n) begin
      @(negedge clk);
      evLo += int'(loEvent);
      evHi += int'(hiEvent);
      if (loEvent && prevLo) backToBack++;
      prevLo = loEvent;
    end
  endtask

  task automatic prep(input logic [1:0] m);
    @(negedge clk);
    loEna = 2'd0; hiEna = 2'd0; loRun = 1'b0; hiRun = 1'b0;
    suspend = 1'b0; freeRun = 1'b0; softStop = 1'b0;
    loadLo = 1'b1; loadHi = 1'b1; loadData = '0; mode = m;
    @(negedge clk);
    loadLo = 1'b0; loadHi = 1'b0; loRun = 1'b1; hiRun = 1'b1;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #1600000;
    errors++; checks++;
    $display("FAIL watchdog: actual running expected done");
    finish();
  end

  initial begin
    int adv;
    int pList[7] = '{1, 4, 9, 255, 256, 300, 511};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 countLo", countLo, 0);
    check("R1 countHi", countHi, 0);
    check("R1 events", {loEvent, hiEvent}, 0);

    // R2 joined counter sweep
    foreach (pList[i]) begin
      prep(2'd0);
      periodHi = W'(pList[i] >> W); periodLo = W'(pList[i]); loEna = 2'd2; hiEna = 2'd0;
      runTicks(700);
      check("R2 wide count", {countHi, countLo}, 700 % (pList[i] + 1));
      check("R2 wide events", evLo, 700 / (pList[i] + 1));
      check("R2 hi quiet", evHi, 0);
    end
    check("R12 no back-to-back", backToBack, 0);

    // R3 independent sweep
    for (int ps = 0; ps < 4; ps++) begin
      for (int q = 1; q < 4; q++) begin
        prep(2'd1);
        periodLo = W'(q + 2); periodHi = W'(q); psPeriod = PW'(ps);
        loEna = 2'd2; hiEna = 2'd2;
        runTicks(60);
        adv = 60 / (ps + 1);
        check("R3 lo count", countLo, 60 % (q + 3));
        check("R3 lo events", evLo, 60 / (q + 3));
        check("R3 hi count", countHi, adv % (q + 1));
        check("R3 hi events", evHi, adv / (q + 1));
      end
    end

    // R4 chained sweep; hiEna set to a non-hold code that must not matter
    for (int a = 0; a < 3; a++) begin
      for (int b = 1; b < 4; b++) begin
        prep(2'd3);
        periodHi = W'(a); periodLo = W'(b); loEna = 2'd2; hiEna = 2'd1;
        runTicks(50);
        adv = 50 / (a + 1);
        check("R4 prescale count", countHi, 50 % (a + 1));
        check("R4 lo count", countLo, adv % (b + 1));
        check("R4 lo events", evLo, adv / (b + 1));
        check("R4 hi quiet", evHi, 0);
      end
    end

    // R5 one-shot
    prep(2'd1);
    periodLo = 8'd5; loEna = 2'd1;
    runTicks(20);
    check("R5 stop count", countLo, 5);
    check("R5 one event", evLo, 1);
    loEna = 2'd0; runTicks(1); loEna = 2'd1;
    runTicks(10);
    check("R5 rearm events", evLo, 1);
    check("R5 rearm count", countLo, 5);

    // R6 hold codes
    prep(2'd1);
    periodLo = 8'd100; loEna = 2'd2;
    runTicks(10);
    loEna = 2'd0; runTicks(10);
    check("R6 hold code 0", countLo, 10);
    loEna = 2'd3; runTicks(10);
    check("R6 hold code 3", countLo, 10);

    // R13 load overrides counting
    loEna = 2'd2; loadLo = 1'b1; loadData = 8'd77;
    @(negedge clk); loadLo = 1'b0;
    check("R13 load value", countLo, 77);
    runTicks(3);
    check("R13 count after load", countLo, 80);

    // R7 loaded above period: 250..255, 0..3 takes 9 ticks, 10th wraps
    prep(2'd1);
    loadLo = 1'b1; loadData = 8'd250;
    @(negedge clk); loadLo = 1'b0;
    periodLo = 8'd3; loEna = 2'd2;
    runTicks(10);
    check("R7 wrap count", countLo, 0);
    check("R7 wrap events", evLo, 1);

    // R8 zero period
    prep(2'd1);
    periodLo = 8'd0; loEna = 2'd2;
    runTicks(10);
    check("R8 zero count", countLo, 0);
    check("R8 zero events", evLo, 0);

    // R9 soft reset
    prep(2'd1);
    periodLo = 8'd100; periodHi = 8'd100; psPeriod = '0; loEna = 2'd2; hiEna = 2'd2;
    runTicks(10);
    loRun = 1'b0; runTicks(10);
    check("R9 lo frozen", countLo, 10);
    check("R9 hi runs", countHi, 20);
    prep(2'd0);
    hiRun = 1'b0; periodLo = 8'd50; periodHi = 8'd0; loEna = 2'd2;
    runTicks(10);
    check("R9 joined needs both", countLo, 0);

    // R10 suspend variants
    prep(2'd1);
    periodLo = 8'd5; loEna = 2'd2; suspend = 1'b1;
    runTicks(10);
    check("R10 hard halt", countLo, 0);
    freeRun = 1'b1; runTicks(10);
    check("R10 free count", countLo, 4);
    check("R10 free events", evLo, 1);
    prep(2'd1);
    periodLo = 8'd5; loEna = 2'd2; suspend = 1'b1; softStop = 1'b1;
    runTicks(20);
    check("R10 soft stop count", countLo, 5);
    check("R10 soft stop events", evLo, 0);
    suspend = 1'b0; runTicks(1);
    check("R10 release count", countLo, 0);
    check("R10 release event", evLo, 1);

    // R11 external clock, both polarities
    prep(2'd1);
    clkSel = 1'b1; periodLo = 8'd200; periodHi = 8'd200; psPeriod = '0;
    loEna = 2'd2; hiEna = 2'd2;
    for (int k = 0; k < 5; k++) begin
      extIn = 1'b1; runTicks(3);
      extIn = 1'b0; runTicks(3);
    end
    runTicks(4);
    check("R11 rising edges", countLo, 5);
    check("R11 upper internal", countHi, 34);
    loEna = 2'd0; hiEna = 2'd0; extInvert = 1'b1;
    runTicks(4);
    prep(2'd1);
    clkSel = 1'b1; periodLo = 8'd200; loEna = 2'd2;
    for (int k = 0; k < 5; k++) begin
      extIn = 1'b1; runTicks(3);
      extIn = 1'b0; runTicks(3);
    end
    runTicks(4);
    check("R11 inverted edges", countLo, 5);

    finish();
  end
endmodule